// File: doc/BRIEF.md
# Bounds-checked tagged array load

This execute-stage unit carries out one fused operation: "load an array element if the access is safe, otherwise branch to a slow path." Each operation brings three things. The first is a 64-bit tagged array reference. The second is a 64-bit index. The third is a branch target.

The reference keeps a 4-bit type tag in bits [63:60], a 12-bit element count in bits [59:48] and the element base address in bits [47:0]. The unit checks two things: that the tag marks an inline, zero-based array of 32-bit integers, and that the index is below the encoded count.

When both checks hold, the unit issues one read on a valid/ready memory port at base + index*4. It then writes the sign-extended word back to the destination register and does not branch. When either check fails, it sends a one-cycle fetch redirect to the target and touches no memory. The software slow path behind the target then handles descriptor-based or oversized arrays. No single operation both loads and branches.

Top module: `tagged_array_load`

## Requirements
- R1: While reset is asserted, and until an operation is accepted after reset, `busy`, `mem_req_valid`, `redir_valid` and `wb_valid` are low.
- R2: An accepted operation whose reference tag (bits [63:60]) is not 4'b1010 produces a redirect to `op_target` and no memory request.
- R3: An accepted operation with the inline tag whose index, taken as an unsigned 64-bit value, is not below the count in bits [59:48] produces a redirect and no memory request. This covers an index equal to the count, a count of zero and a negative index.
- R4: An accepted operation that passes both checks raises `mem_req_valid` in the following cycle. The request address is bits [47:0] plus four times the index, modulo 2^48. Valid and address hold steady until `mem_req_ready` is sampled high.
- R5: After the response handshake, `wb_valid` pulses for one cycle. `wb_data` carries the 32-bit response sign-extended to 64 bits, `wb_rd` carries the operation's `op_rd`, and no redirect is produced for that operation.
- R6: `redir_valid` and `mem_req_valid` are never high in the same cycle, and an operation causes exactly one of a redirect or a memory request.
- R7: `busy` is high from the cycle after a passing operation is accepted until the cycle after its response arrives. Operations presented while `busy` is high are ignored: they cause no redirect, request or write-back.
- R8: The inline count field reaches 4095. A count of 1024 or of 4095 is served as a load, with index 4094 loading and 4095 redirecting. An 8192-element array, which the field cannot hold, carries a non-inline tag and is redirected.
- R9: Each failing operation yields its own one-cycle `redir_valid` pulse in the cycle after acceptance, carrying its target. Back-to-back failing operations yield back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation presented; taken when `busy` is low |
| op_ref | input | 64 | Tagged array reference: tag, count, base |
| op_index | input | 64 | Element index, unsigned |
| op_target | input | 48 | Slow-path branch target |
| op_rd | input | 5 | Destination register number |
| busy | output | 1 | A load is outstanding; new operations are not taken |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 48 | Byte address of the element |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| wb_valid | output | 1 | Write-back pulse |
| wb_rd | output | 5 | Write-back register number |
| wb_data | output | 64 | Sign-extended loaded element |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_target | output | 48 | Redirect address |

## Verification
The bench builds the unit with its default parameters: 48-bit addresses, a 12-bit count field, the 4'b1010 inline tag and 4-byte elements. With these values, count values of 0, 1024 and 4095 and a base near the top of the 48-bit space are all reachable, so the exact bound edges and the address wrap are exercised. The memory model holds ready low for zero to two cycles per request and returns words whose sign follows an address bit. This brings both sign-extension polarities within reach, along with request holding under back-pressure and operations pushed at the unit while it is busy.

// File: rtl/tal_pkg.sv
package tal_pkg;
  typedef enum logic [1:0] {
    TAL_IDLE = 2'd0,
    TAL_REQ  = 2'd1,
    TAL_WAIT = 2'd2
  } tal_state_e;
endpackage

// File: rtl/tal_check.sv
module tal_check #(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 12,
  parameter int TAG_W  = 4,
  parameter logic [TAG_W-1:0] TAG_INLINE = 4'b1010
) (
  input  logic [XLEN-1:0]   ref_i,
  input  logic [XLEN-1:0]   index_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              pass_o
);
  localparam int LEN_LO = ADDR_W;
  localparam int TAG_LO = ADDR_W + LEN_W;

  logic [TAG_W-1:0] tag;
  logic [LEN_W-1:0] count;
  logic             tag_ok;
  logic             idx_ok;

  always_comb begin
    tag    = ref_i[TAG_LO +: TAG_W];
    count  = ref_i[LEN_LO +: LEN_W];
    base_o = ref_i[ADDR_W-1:0];
    tag_ok = (tag == TAG_INLINE);
    idx_ok = (index_i < {{(XLEN-LEN_W){1'b0}}, count});
    pass_o = tag_ok && idx_ok;
  end
endmodule

// File: rtl/tal_agu.sv
module tal_agu #(
  parameter int ADDR_W     = 48,
  parameter int ELEM_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    addr_o = base_i + (index_i << ELEM_SHIFT);
  end
endmodule

// File: rtl/tal_ctrl.sv
module tal_ctrl
  import tal_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 48,
  parameter int ELEM_W = 32,
  parameter int RD_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              pass,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] target_in,
  input  logic [RD_W-1:0]   rd_in,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ELEM_W-1:0] mem_rsp_data,
  output logic              wb_valid,
  output logic [RD_W-1:0]   wb_rd,
  output logic [XLEN-1:0]   wb_data,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_target
);
  tal_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [RD_W-1:0]   rd_q;
  logic [ADDR_W-1:0] redir_t_q;
  logic              redir_v_q, redir_v_d;
  logic              wb_v_q, wb_v_d;
  logic [RD_W-1:0]   wb_rd_q;
  logic [XLEN-1:0]   wb_d_q;

  logic accept, take_load, take_redir, req_fire, rsp_fire;

  always_comb begin
    accept     = op_valid && (state_q == TAL_IDLE);
    take_load  = accept && pass;
    take_redir = accept && !pass;
    req_fire   = (state_q == TAL_REQ) && mem_req_ready;
    rsp_fire   = (state_q == TAL_WAIT) && mem_rsp_valid;
    redir_v_d  = take_redir;
    wb_v_d     = rsp_fire;
    state_d    = state_q;
    unique case (state_q)
      TAL_IDLE: if (take_load) state_d = TAL_REQ;
      TAL_REQ:  if (req_fire)  state_d = TAL_WAIT;
      TAL_WAIT: if (rsp_fire)  state_d = TAL_IDLE;
      default:                 state_d = TAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TAL_IDLE;
      redir_v_q <= 1'b0;
      wb_v_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      redir_v_q <= redir_v_d;
      wb_v_q    <= wb_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= '0;
    end else if (take_load) begin
      addr_q <= addr_in;
      rd_q   <= rd_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_t_q <= '0;
    end else if (take_redir) begin
      redir_t_q <= target_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_rd_q <= '0;
      wb_d_q  <= '0;
    end else if (rsp_fire) begin
      wb_rd_q <= rd_q;
      wb_d_q  <= {{(XLEN-ELEM_W){mem_rsp_data[ELEM_W-1]}}, mem_rsp_data};
    end
  end

  always_comb begin
    busy          = (state_q != TAL_IDLE);
    mem_req_valid = (state_q == TAL_REQ);
    mem_req_addr  = addr_q;
    redir_valid   = redir_v_q;
    redir_target  = redir_t_q;
    wb_valid      = wb_v_q;
    wb_rd         = wb_rd_q;
    wb_data       = wb_d_q;
  end
endmodule

// File: rtl/tagged_array_load.sv
module tagged_array_load #(
  parameter int XLEN       = 64,
  parameter int ADDR_W     = 48,
  parameter int LEN_W      = 12,
  parameter int TAG_W      = 4,
  parameter logic [TAG_W-1:0] TAG_INLINE = 4'b1010,
  parameter int ELEM_SHIFT = 2,
  parameter int ELEM_W     = 32,
  parameter int RD_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [XLEN-1:0]   op_ref,
  input  logic [XLEN-1:0]   op_index,
  input  logic [ADDR_W-1:0] op_target,
  input  logic [RD_W-1:0]   op_rd,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ELEM_W-1:0] mem_rsp_data,
  output logic              wb_valid,
  output logic [RD_W-1:0]   wb_rd,
  output logic [XLEN-1:0]   wb_data,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_target
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] elem_addr;
  logic              pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  tal_check #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W),
    .TAG_INLINE(TAG_INLINE)
  ) u_check (
    .ref_i(op_ref), .index_i(op_index), .base_o(base), .pass_o(pass)
  );

  tal_agu #(.ADDR_W(ADDR_W), .ELEM_SHIFT(ELEM_SHIFT)) u_agu (
    .base_i(base), .index_i(op_index[ADDR_W-1:0]), .addr_o(elem_addr)
  );

  tal_ctrl #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .RD_W(RD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .op_valid(op_valid), .pass(pass),
    .addr_in(elem_addr), .target_in(op_target), .rd_in(op_rd),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .wb_valid(wb_valid), .wb_rd(wb_rd),
    .wb_data(wb_data), .redir_valid(redir_valid), .redir_target(redir_target)
  );
endmodule

// File: rtl/tal_checker.sv
module tal_checker #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              wb_valid,
  input logic              redir_valid
);
  // R6
  a_r6_no_branch_and_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_valid && mem_req_valid));

  // R4
  a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7
  a_r7_request_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  // R7
  a_r7_busy_until_response: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rsp_valid) |=> busy);

  // R9
  a_r9_redirect_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(op_valid && !busy));

  // R5
  a_r5_writeback_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
endmodule

bind tagged_array_load tal_checker #(.ADDR_W(ADDR_W)) u_tal_checker (
  .clk(clk), .rst_n(rst_sync_n), .op_valid(op_valid), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .wb_valid(wb_valid), .redir_valid(redir_valid)
);

// File: tb/tagged_array_load_bench.sv
module tagged_array_load_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [63:0] op_ref;
  logic [63:0] op_index;
  logic [47:0] op_target;
  logic [4:0]  op_rd;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        wb_valid;
  logic [4:0]  wb_rd;
  logic [63:0] wb_data;
  logic        redir_valid;
  logic [47:0] redir_target;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_array_load u_tagged_array_load (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ref(op_ref),
    .op_index(op_index), .op_target(op_target), .op_rd(op_rd), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .wb_valid(wb_valid), .wb_rd(wb_rd),
    .wb_data(wb_data), .redir_valid(redir_valid), .redir_target(redir_target)
  );

  typedef struct {
    bit          is_redir;
    logic [47:0] addr;
    logic [63:0] data;
    logic [4:0]  rd;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  bit   mon_on  = 1'b0;
  int   n_req   = 0;
  int   stall   = 0;
  bit   in_req  = 1'b0;
  bit   rsp_pend = 1'b0;
  logic [31:0] rsp_word;

  function automatic logic [31:0] mem_word(input logic [47:0] a);
    return {a[2], a[30:0] ^ 31'h0123_4567};
  endfunction

  function automatic logic [63:0] mkref(input logic [3:0] tag, input logic [11:0] cnt,
                                        input logic [47:0] base);
    return {tag, cnt, base};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: models the requirements to push the expected result.
  task automatic issue(input logic [63:0] r, input logic [63:0] idx,
                       input logic [47:0] tgt, input logic [4:0] rd,
                       input string req, input bit poke);
    exp_t e;
    bit   pass;
    pass = (r[63:60] == 4'b1010) && (idx < {52'd0, r[59:48]});
    e.is_redir = !pass;
    e.rd  = rd;
    e.req = req;
    if (pass) begin
      e.addr = r[47:0] + (idx[47:0] << 2);
      e.data = {{32{mem_word(e.addr)[31]}}, mem_word(e.addr)};
    end else begin
      e.addr = tgt;
      e.data = '0;
    end
    while (busy) @(negedge clk);
    q.push_back(e);
    op_valid = 1'b1; op_ref = r; op_index = idx; op_target = tgt; op_rd = rd;
    @(negedge clk);
    if (poke) begin
      // R7: a failing operation held at the port while busy must be ignored
      op_ref = mkref(4'h0, 12'd0, 48'h0); op_index = 64'd0;
      op_target = 48'h0000_DEAD_0000; op_rd = 5'd31;
      while (busy) @(negedge clk);
    end
    op_valid = 1'b0;
  endtask

  // Monitor and memory model
  always @(negedge clk) begin
    if (mon_on) begin
      if (rsp_pend) begin
        mem_rsp_valid <= 1'b1; mem_rsp_data <= rsp_word; rsp_pend = 1'b0;
      end else begin
        mem_rsp_valid <= 1'b0;
      end
      if (mem_req_valid) begin
        if (!in_req) begin in_req = 1'b1; stall = n_req % 3; n_req++; end
        if (stall > 0) begin
          stall--; mem_req_ready <= 1'b0;
        end else begin
          mem_req_ready <= 1'b1;
          in_req = 1'b0;
          rsp_pend = 1'b1;
          rsp_word = mem_word(mem_req_addr);
          if (q.size() == 0 || q[0].is_redir)
            check(1'b0, (q.size() == 0) ? "R6" : q[0].req, "unexpected memory request",
                  {16'd0, mem_req_addr}, 64'd0);
          else
            check(mem_req_addr == q[0].addr, "R4", "request address",
                  {16'd0, mem_req_addr}, {16'd0, q[0].addr});
        end
      end else begin
        mem_req_ready <= 1'b0;
      end
      if (wb_valid) begin
        if (q.size() == 0 || q[0].is_redir) begin
          check(1'b0, "R5", "unexpected write-back", wb_data, 64'd0);
        end else begin
          check(wb_data == q[0].data && wb_rd == q[0].rd, q[0].req, "write-back",
                {wb_rd, wb_data[58:0]}, {q[0].rd, q[0].data[58:0]});
          check(!redir_valid, "R5", "redirect during load", {63'd0, redir_valid}, 64'd0);
          void'(q.pop_front());
        end
      end
      if (redir_valid) begin
        if (q.size() == 0 || !q[0].is_redir) begin
          check(1'b0, "R9", "unexpected redirect", {16'd0, redir_target}, 64'd0);
        end else begin
          check(redir_target == q[0].addr, q[0].req, "redirect target",
                {16'd0, redir_target}, {16'd0, q[0].addr});
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_ref = '0; op_index = '0; op_target = '0;
    op_rd = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_req_valid && !redir_valid && !wb_valid, "R1", "outputs in reset",
          {60'd0, busy, mem_req_valid, redir_valid, wb_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !mem_req_valid && !redir_valid && !wb_valid, "R1", "outputs after reset",
          {60'd0, busy, mem_req_valid, redir_valid, wb_valid}, 64'd0);
    mon_on = 1'b1;

    issue(mkref(4'b1010, 12'd1024, 48'h0000_1000_0000), 64'd0,    48'h100, 5'd1, "R8", 1'b0);
    issue(mkref(4'b1010, 12'd1024, 48'h0000_1000_0000), 64'd1023, 48'h104, 5'd2, "R5", 1'b0);
    issue(mkref(4'b1010, 12'd1024, 48'h0000_1000_0000), 64'd1024, 48'h108, 5'd3, "R3", 1'b0);
    issue(mkref(4'b1010, 12'd1024, 48'h0000_1000_0000), -64'sd1,  48'h10C, 5'd4, "R3", 1'b0);
    issue(mkref(4'b1010, 12'd0,    48'h0000_2000_0000), 64'd0,    48'h110, 5'd5, "R3", 1'b0);
    issue(mkref(4'b0000, 12'd100,  48'h0000_3000_0000), 64'd5,    48'h114, 5'd6, "R2", 1'b0);
    issue(mkref(4'b1011, 12'd100,  48'h0000_3000_0000), 64'd5,    48'h118, 5'd7, "R2", 1'b0);
    issue(mkref(4'b1010, 12'd4095, 48'h0000_4000_0000), 64'd4094, 48'h11C, 5'd8, "R8", 1'b0);
    issue(mkref(4'b1010, 12'd4095, 48'h0000_4000_0000), 64'd4095, 48'h120, 5'd9, "R8", 1'b0);
    // 8192 elements does not fit the count field; such an array carries a non-inline tag
    issue(mkref(4'b1100, 12'd0,    48'h0000_5000_0000), 64'd10,   48'h124, 5'd10, "R8", 1'b0);
    issue(mkref(4'b1010, 12'd64,   48'hFFFF_FFFF_FFF0), 64'd8,    48'h128, 5'd11, "R4", 1'b0);
    issue(mkref(4'b1010, 12'd16,   48'h0000_6000_0000), 64'd3,    48'h12C, 5'd12, "R7", 1'b1);
    issue(mkref(4'b1010, 12'd16,   48'h0000_6000_0000), 64'd16,   48'h130, 5'd13, "R9", 1'b0);
    issue(mkref(4'b0001, 12'd16,   48'h0000_6000_0000), 64'd1,    48'h134, 5'd14, "R9", 1'b0);
    issue(mkref(4'b1010, 12'd16,   48'h0000_6000_0000), 64'd20,   48'h138, 5'd15, "R6", 1'b0);
    issue(mkref(4'b1010, 12'd16,   48'h0000_6000_0000), 64'd2,    48'h13C, 5'd16, "R6", 1'b0);

    repeat (12) @(negedge clk);
    check(q.size() == 0, "R6", "results outstanding", q.size(), 64'd0);
    check(!busy, "R7", "busy after last response", {63'd0, busy}, 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule